// File: doc/BRIEF.md
# Long-Instruction Slot Dispatcher

The dispatcher accepts one wide instruction word per clock. Each word holds five fixed operation slots and one shared immediate. It routes every slot straight to the functional unit tied to that slot position. Slot 0 and slot 1 feed the two memory units, slot 2 and slot 3 feed the two floating-point units, and slot 4 feeds the integer/branch unit. The dispatcher never compares registers between slots and never stalls on its own. Scheduling is left to the compiler, which fills any unused slot with a no-operation.

Each operation is 16 bits wide. From most to least significant, it holds a 4-bit opcode, a destination register, a first source register and a second source register, each register field 4 bits wide. A zero opcode is a no-operation and issues nothing. When opcode bit 3 is set, the unit takes the word's shared 16-bit immediate in place of its second source. All outputs are registered, which gives one cycle of latency. A global stall input freezes every unit's outputs together.

Top module: `vliw_slot_dispatch`

## Requirements
- R1: While `rst` is high at a rising edge, every unit output (valid, opcode, register fields, immediate select, immediate) is zero on the following cycle. Reset takes priority over `stall`.
- R2: Slot k occupies `in_word[16+16k +: 16]`, with opcode in bits [15:12], destination in [11:8], first source in [7:4] and second source in [3:0]. When the slot's operation issues, unit k presents exactly these fields one cycle after the edge that captured the word.
- R3: A slot whose opcode is zero drives its unit's valid low, and that unit's opcode, register, select and immediate outputs are zero.
- R4: When `in_vld` is low and `stall` is low, every unit's valid and fields are zero on the next cycle, whatever `in_word` holds.
- R5: An issued operation whose opcode bit 3 is set asserts its unit's `u_use_imm` bit. Otherwise `u_use_imm` is low and the unit's immediate output is zero.
- R6: The shared immediate `in_word[15:0]` is copied unchanged to every unit whose operation has its select bit set, in the same cycle.
- R7: While `stall` is high and `rst` is low, all unit outputs keep their values, whatever the inputs do.
- R8: Operations are issued without any dependency check. Slots that name the same destination, or that read another slot's destination, are passed through unchanged in the same cycle.
- R9: A new word is accepted on every unstalled cycle, so back-to-back words leave the outputs one after another with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Holds all unit outputs |
| in_vld | input | 1 | Qualifies `in_word` |
| in_word | input | 96 | Five 16-bit slots above a 16-bit shared immediate |
| u_vld | output | 5 | Per-unit issue valid, bit k is unit k |
| u_opc | output | 20 | Per-unit opcode, 4 bits per unit |
| u_rd | output | 20 | Per-unit destination register field |
| u_rs1 | output | 20 | Per-unit first source register field |
| u_rs2 | output | 20 | Per-unit second source register field |
| u_use_imm | output | 5 | Per-unit immediate select |
| u_imm | output | 80 | Per-unit immediate, 16 bits per unit |

## Verification
Directed words are applied first: every slot carries a distinct opcode and distinct register fields, which shows whether any slot is routed to the wrong unit or a field is taken from the wrong bits. Words that mix no-operations, immediate-select opcodes and invalid flags separate the issue gating from the immediate routing. A word whose slots deliberately share and reuse one register shows that nothing between slots is interlocked. Stall runs with changing inputs, and a reset asserted during a stall, test the hold and its priority. A long stream of random words with random stalls then compares every unit on every cycle against a behavioural model.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;
  localparam int unsigned DEF_SLOTS = 5;
  localparam int unsigned DEF_OPC_W = 4;
  localparam int unsigned DEF_REG_W = 4;
  localparam int unsigned DEF_IMM_W = 16;

  typedef enum logic [2:0] {
    UNIT_MEM0 = 3'd0,
    UNIT_MEM1 = 3'd1,
    UNIT_FP0  = 3'd2,
    UNIT_FP1  = 3'd3,
    UNIT_INT  = 3'd4
  } unit_e;
endpackage

// File: rtl/vliw_slot_decode.sv
module vliw_slot_decode #(
  parameter int unsigned OPC_W = 4,
  parameter int unsigned REG_W = 4,
  parameter int unsigned IMM_W = 16,
  localparam int unsigned OP_W = OPC_W + 3 * REG_W
) (
  input  logic [OP_W-1:0]  op,
  input  logic             word_vld,
  input  logic [IMM_W-1:0] shared_imm,
  output logic             issue,
  output logic [OPC_W-1:0] opc,
  output logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] rs1,
  output logic [REG_W-1:0] rs2,
  output logic             use_imm,
  output logic [IMM_W-1:0] imm
);
  logic [OPC_W-1:0] raw_opc;

  always_comb begin
    raw_opc = op[OP_W-1 -: OPC_W];
    issue   = word_vld && (raw_opc != '0);
    opc     = '0;
    rd      = '0;
    rs1     = '0;
    rs2     = '0;
    use_imm = 1'b0;
    imm     = '0;
    if (issue) begin
      opc     = raw_opc;
      rd      = op[3*REG_W-1 -: REG_W];
      rs1     = op[2*REG_W-1 -: REG_W];
      rs2     = op[REG_W-1:0];
      use_imm = raw_opc[OPC_W-1];
      if (raw_opc[OPC_W-1]) imm = shared_imm;
    end
  end
endmodule

// File: rtl/vliw_slot_reg.sv
module vliw_slot_reg #(
  parameter int unsigned W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stall,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (!stall) q <= d;
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(q));

  p_one_cycle_load_r9: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (q == $past(d)));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/vliw_slot_dispatch.sv
module vliw_slot_dispatch
  import vliw_disp_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned OPC_W = DEF_OPC_W,
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned IMM_W = DEF_IMM_W,
  localparam int unsigned OP_W   = OPC_W + 3 * REG_W,
  localparam int unsigned WORD_W = SLOTS * OP_W + IMM_W,
  localparam int unsigned REC_W  = 2 + OPC_W + 3 * REG_W + IMM_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stall,
  input  logic                     in_vld,
  input  logic [WORD_W-1:0]        in_word,
  output logic [SLOTS-1:0]         u_vld,
  output logic [SLOTS*OPC_W-1:0]   u_opc,
  output logic [SLOTS*REG_W-1:0]   u_rd,
  output logic [SLOTS*REG_W-1:0]   u_rs1,
  output logic [SLOTS*REG_W-1:0]   u_rs2,
  output logic [SLOTS-1:0]         u_use_imm,
  output logic [SLOTS*IMM_W-1:0]   u_imm
);
  logic [IMM_W-1:0] shared_imm;
  assign shared_imm = in_word[IMM_W-1:0];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic             d_iss, d_use;
    logic [OPC_W-1:0] d_opc;
    logic [REG_W-1:0] d_rd, d_rs1, d_rs2;
    logic [IMM_W-1:0] d_imm;
    logic [REC_W-1:0] d_rec, q_rec;

    vliw_slot_decode #(.OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W)) dec_i (
      .op         (in_word[IMM_W + k*OP_W +: OP_W]),
      .word_vld   (in_vld),
      .shared_imm (shared_imm),
      .issue      (d_iss),
      .opc        (d_opc),
      .rd         (d_rd),
      .rs1        (d_rs1),
      .rs2        (d_rs2),
      .use_imm    (d_use),
      .imm        (d_imm)
    );

    assign d_rec = {d_iss, d_use, d_opc, d_rd, d_rs1, d_rs2, d_imm};

    vliw_slot_reg #(.W(REC_W)) reg_i (
      .clk   (clk),
      .rst   (rst),
      .stall (stall),
      .d     (d_rec),
      .q     (q_rec)
    );

    assign {u_vld[k], u_use_imm[k], u_opc[k*OPC_W +: OPC_W],
            u_rd[k*REG_W +: REG_W], u_rs1[k*REG_W +: REG_W],
            u_rs2[k*REG_W +: REG_W], u_imm[k*IMM_W +: IMM_W]} = q_rec;

    p_valid_has_opcode_r3: assert property (@(posedge clk) disable iff (rst)
      u_vld[k] |-> (u_opc[k*OPC_W +: OPC_W] != '0));

    p_idle_unit_clear_r3: assert property (@(posedge clk) disable iff (rst)
      !u_vld[k] |-> (u_opc[k*OPC_W +: OPC_W] == '0 && !u_use_imm[k]
                     && u_imm[k*IMM_W +: IMM_W] == '0));

    p_imm_needs_select_r5: assert property (@(posedge clk) disable iff (rst)
      (u_imm[k*IMM_W +: IMM_W] != '0) |-> u_use_imm[k]);

    p_select_tracks_opbit_r5: assert property (@(posedge clk) disable iff (rst)
      u_vld[k] |-> (u_use_imm[k] == u_opc[k*OPC_W + OPC_W - 1]));
  end

  p_invalid_word_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !stall) |=> (u_vld == '0));

  p_shared_imm_equal_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(u_use_imm) >= 2 && u_use_imm[0] && u_use_imm[SLOTS-1])
      |-> (u_imm[IMM_W-1:0] == u_imm[(SLOTS-1)*IMM_W +: IMM_W]));
endmodule

// File: tb/vliw_slot_dispatch_tb_top.sv
module vliw_slot_dispatch_tb_top;
  localparam int NU = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        in_vld = 1'b0;
  logic [95:0] in_word = '0;
  logic [NU-1:0]    u_vld, u_use_imm;
  logic [NU*4-1:0]  u_opc, u_rd, u_rs1, u_rs2;
  logic [NU*16-1:0] u_imm;

  always #4 clk = ~clk;

  vliw_slot_dispatch dut_i (
    .clk(clk), .rst(rst), .stall(stall), .in_vld(in_vld), .in_word(in_word),
    .u_vld(u_vld), .u_opc(u_opc), .u_rd(u_rd), .u_rs1(u_rs1), .u_rs2(u_rs2),
    .u_use_imm(u_use_imm), .u_imm(u_imm)
  );

  int total = 0;
  int bad = 0;
  string drv_tag = "R1";
  string exp_tag = "R1";

  int e_vld [NU];
  int e_opc [NU];
  int e_rd  [NU];
  int e_rs1 [NU];
  int e_rs2 [NU];
  int e_use [NU];
  int e_imm [NU];

  initial for (int u = 0; u < NU; u++) begin
    e_vld[u] = 0; e_opc[u] = 0; e_rd[u] = 0; e_rs1[u] = 0;
    e_rs2[u] = 0; e_use[u] = 0; e_imm[u] = 0;
  end

  // Behavioural reference: one output stage updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      exp_tag = drv_tag;
      for (int u = 0; u < NU; u++) begin
        e_vld[u] = 0; e_opc[u] = 0; e_rd[u] = 0; e_rs1[u] = 0;
        e_rs2[u] = 0; e_use[u] = 0; e_imm[u] = 0;
      end
    end else if (!stall) begin
      exp_tag = drv_tag;
      for (int u = 0; u < NU; u++) begin
        int op, oc;
        op = int'(in_word[16 + 16*u +: 16]);
        oc = (op / 4096) % 16;
        if (in_vld && oc != 0) begin
          e_vld[u] = 1;
          e_opc[u] = oc;
          e_rd[u]  = (op / 256) % 16;
          e_rs1[u] = (op / 16) % 16;
          e_rs2[u] = op % 16;
          e_use[u] = (oc >= 8) ? 1 : 0;
          e_imm[u] = (oc >= 8) ? int'(in_word[15:0]) : 0;
        end else begin
          e_vld[u] = 0; e_opc[u] = 0; e_rd[u] = 0; e_rs1[u] = 0;
          e_rs2[u] = 0; e_use[u] = 0; e_imm[u] = 0;
        end
      end
    end else begin
      exp_tag = (drv_tag == "R7") ? "R7" : exp_tag;
    end
  end

  task automatic compare_all();
    for (int u = 0; u < NU; u++) begin
      int a_v, a_o, a_d, a_1, a_2, a_s, a_i;
      a_v = int'(u_vld[u]);      a_o = int'(u_opc[4*u +: 4]);
      a_d = int'(u_rd[4*u +: 4]); a_1 = int'(u_rs1[4*u +: 4]);
      a_2 = int'(u_rs2[4*u +: 4]); a_s = int'(u_use_imm[u]);
      a_i = int'(u_imm[16*u +: 16]);
      total++;
      if (a_v !== e_vld[u] || a_o !== e_opc[u] || a_d !== e_rd[u] ||
          a_1 !== e_rs1[u] || a_2 !== e_rs2[u] || a_s !== e_use[u] ||
          a_i !== e_imm[u]) begin
        bad++;
        $display("FAIL %s unit%0d actual v=%0d op=%h rd=%h rs1=%h rs2=%h sel=%0d imm=%h expected v=%0d op=%h rd=%h rs1=%h rs2=%h sel=%0d imm=%h",
                 exp_tag, u, a_v, a_o, a_d, a_1, a_2, a_s, a_i,
                 e_vld[u], e_opc[u], e_rd[u], e_rs1[u], e_rs2[u], e_use[u], e_imm[u]);
      end
    end
  endtask

  task automatic cyc(input logic r, input logic s, input logic v,
                     input logic [95:0] w, input string t);
    @(negedge clk);
    compare_all();
    rst = r; stall = s; in_vld = v; in_word = w; drv_tag = t;
  endtask

  function automatic logic [15:0] mk(input int oc, input int d, input int a, input int b);
    return {oc[3:0], d[3:0], a[3:0], b[3:0]};
  endfunction

  initial begin
    // R1: reset with a live word on the inputs
    cyc(1, 0, 1, {mk(1,1,1,1), mk(2,2,2,2), mk(3,3,3,3), mk(4,4,4,4), mk(5,5,5,5), 16'hBEEF}, "R1");
    cyc(1, 0, 1, '1, "R1");
    // R2: distinct fields per slot
    cyc(0, 0, 1, {mk(7,4,3,2), mk(6,9,8,7), mk(5,1,2,3), mk(3,12,13,14), mk(1,15,10,5), 16'h1234}, "R2");
    cyc(0, 0, 1, {mk(2,1,2,3), mk(4,5,6,7), mk(6,9,10,11), mk(7,13,14,15), mk(3,0,1,2), 16'h0F0F}, "R2");
    // R3: no-operations in some slots
    cyc(0, 0, 1, {mk(0,9,9,9), mk(5,1,2,3), mk(0,15,15,15), mk(1,4,5,6), mk(0,7,7,7), 16'hAAAA}, "R3");
    cyc(0, 0, 1, {80'h0, 16'hFFFF}, "R3");
    // R5 / R6: immediate selects
    cyc(0, 0, 1, {mk(8,1,2,3), mk(3,4,5,6), mk(9,7,8,9), mk(15,10,11,12), mk(12,1,1,1), 16'hC0DE}, "R6");
    cyc(0, 0, 1, {mk(8,0,0,0), mk(8,1,1,1), mk(8,2,2,2), mk(8,3,3,3), mk(8,4,4,4), 16'h0000}, "R5");
    cyc(0, 0, 1, {mk(1,1,1,1), mk(7,2,2,2), mk(0,3,3,3), mk(14,4,4,4), mk(2,5,5,5), 16'h5A5A}, "R5");
    // R4: invalid word with nonzero content
    cyc(0, 0, 0, {mk(9,1,2,3), mk(5,4,5,6), mk(6,7,8,9), mk(3,1,1,1), mk(8,2,2,2), 16'h7777}, "R4");
    // R8: same destination and read-after-write inside one word, back to back
    cyc(0, 0, 1, {mk(1,5,0,1), mk(2,5,5,5), mk(3,6,5,2), mk(4,5,6,5), mk(9,5,5,5), 16'h0005}, "R8");
    cyc(0, 0, 1, {mk(2,6,5,5), mk(1,5,6,6), mk(3,5,5,6), mk(4,6,6,5), mk(5,6,5,6), 16'h0006}, "R8");
    // R7: stall with changing inputs, then reset during stall
    cyc(0, 0, 1, {mk(10,3,4,5), mk(2,6,7,8), mk(3,9,10,11), mk(4,12,13,14), mk(5,15,0,1), 16'h9999}, "R7");
    cyc(0, 1, 1, '1, "R7");
    cyc(0, 1, 0, '0, "R7");
    cyc(0, 1, 1, {mk(1,1,1,1), mk(1,1,1,1), mk(1,1,1,1), mk(1,1,1,1), mk(1,1,1,1), 16'h1111}, "R7");
    cyc(0, 0, 1, {mk(1,1,1,1), mk(1,1,1,1), mk(1,1,1,1), mk(1,1,1,1), mk(1,1,1,1), 16'h1111}, "R7");
    cyc(1, 1, 1, '1, "R1");
    cyc(0, 0, 1, '1, "R9");
    // R9: random stream with random stalls
    for (int i = 0; i < 400; i++) begin
      logic [95:0] w;
      w = {$urandom, $urandom, $urandom};
      cyc(0, ($urandom % 5) == 0, ($urandom % 8) != 0, w, "R9");
    end
    cyc(0, 0, 0, '0, "R4");
    cyc(0, 0, 0, '0, "R4");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule